// File: doc/BRIEF.md
# RTC Prescaler and Periodic-Rate Generator

This block divides a 32.768 kHz oscillator clock down to the one-second update tick that drives a real-time clock's time and calendar counters. It also produces a periodic interrupt flag at a software-selected rate. A 7-bit control register holds a 3-bit divider-mode field and a 4-bit rate field. One mode runs the chain. One mode holds it at its half-way point, so that the first tick after release comes exactly half a second later. Every other mode freezes the chain where it stands.

Before each tick the block raises an update-warning output. The warning stays high until the time core reports that its update has finished, and software reads it back as the top bit of the control register. The periodic flag is set on every edge of the selected rate. It is held until the time core acknowledges that software has read it.

Top module: `rtc_prescale_rate`

## Requirements
- R1: After reset the control register reads 0x26 (mode 010, rate 0110), and `sec_tick`, `upd_warn` and `per_flag` are low.
- R2: A cycle with `cfg_wr` high loads `cfg_wdata` into the register. `cfg_rdata[6:0]` returns the stored value: mode in bits 6:4, rate in bits 3:0. `cfg_rdata[7]` returns `upd_warn`.
- R3: In mode 010 the chain advances once per clock, and `sec_tick` is a single-cycle pulse every 32768 cycles.
- R4: Mode 111 holds the chain at its half-way count and produces no ticks. After a write of mode 010, the first `sec_tick` is high 16384 cycles after the write edge.
- R5: Any mode other than 010 and 111 freezes the chain without reloading it. The next tick is delayed by exactly the number of frozen cycles.
- R6: Rate codes 3 to 15 set `per_flag` once every 2^(code-1) cycles: code 3 gives 4 cycles (8192 Hz), code 6 gives 32 cycles (1024 Hz) and code 15 gives 16384 cycles (2 Hz).
- R7: Rate code 1 behaves as code 8 (128 cycles) and rate code 2 behaves as code 9 (256 cycles).
- R8: Rate code 0 never sets `per_flag`.
- R9: `per_flag` stays high until a cycle with `flag_ack` high clears it. A rate edge in the same cycle as `flag_ack` wins, and the flag stays set.
- R10: `upd_warn` rises 8 cycles before each `sec_tick` and stays high across the tick until `upd_done` is pulsed. Entering mode 111 also clears it.
- R11: While the chain is held or frozen, no periodic rate edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Write data: mode [6:4], rate [3:0] |
| cfg_rdata | output | 8 | Read data: warning [7], mode [6:4], rate [3:0] |
| upd_done | input | 1 | Pulse from the time core when its update has finished |
| flag_ack | input | 1 | Clears the periodic flag (register C read in the time core) |
| sec_tick | output | 1 | One-cycle pulse once per second |
| upd_warn | output | 1 | Update warning, high ahead of and after each tick |
| per_flag | output | 1 | Sticky periodic interrupt flag |

## Verification
A wrong count in the chain first shows as a misplaced tick, and that can take up to one second to appear. For this reason the bench times the first tick after a hold release to the exact cycle. It also times a tick after a frozen stretch of random length, so that any stray increment or any missed reload becomes a fixed-offset error within one second. A wrong rate decode shows within two periods of the selected rate, so every code, including the two aliases, is timed against its expected spacing. Warning and flag errors show within one cycle of the tick, the acknowledge, the done pulse or the mode change that should move them.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;

    localparam logic [2:0] DSEL_RUN  = 3'b010;
    localparam logic [2:0] DSEL_HOLD = 3'b111;

    typedef struct packed {
        logic [2:0] dsel;
        logic [3:0] rsel;
    } rtcp_cfg_t;

    // Map the two alias codes onto their slower equivalents.
    function automatic logic [3:0] rtcp_eff_rate(input logic [3:0] code);
        logic [3:0] r;
        case (code)
            4'd1:    r = 4'd8;
            4'd2:    r = 4'd9;
            default: r = code;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtcp_div_chain.sv
module rtcp_div_chain #(
    parameter int DIV_W     = 15,
    parameter int WARN_LEAD = 8
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             run,
    input  logic             hold,
    output logic [DIV_W-1:0] cnt,
    output logic             wrap_evt,
    output logic             warn_evt
);
    localparam logic [DIV_W-1:0] HALF    = {1'b1, {(DIV_W-1){1'b0}}};
    localparam logic [DIV_W-1:0] CNT_MAX = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] WARN_AT = CNT_MAX - DIV_W'(WARN_LEAD);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.cnt = HALF;
        end else if (run) begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: HALF};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign wrap_evt = run && (st_q.cnt == CNT_MAX);
    assign warn_evt = run && (st_q.cnt == WARN_AT);

endmodule

// File: rtl/rtcp_rate_tap.sv
module rtcp_rate_tap #(
    parameter int DIV_W = 15
) (
    input  logic [DIV_W-1:0] cnt,
    input  logic             run,
    input  logic [3:0]       rate_code,
    output logic             per_evt
);
    import rtcp_pkg::*;

    logic [DIV_W-1:0] ones;
    logic [3:0]       eff;
    int               idx;

    // ones[i] is high when the low i+1 chain bits are all set.
    for (genvar i = 0; i < DIV_W; i++) begin : g_tap
        assign ones[i] = &cnt[i:0];
    end

    always_comb begin
        eff     = rtcp_eff_rate(rate_code);
        idx     = int'(eff) - 2;
        per_evt = 1'b0;
        if (run && (eff != 4'd0) && (idx >= 0) && (idx < DIV_W)) begin
            per_evt = ones[idx];
        end
    end

endmodule

// File: rtl/rtcp_status.sv
module rtcp_status (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic wrap_evt,
    input  logic warn_evt,
    input  logic per_evt,
    input  logic upd_done,
    input  logic hold,
    input  logic flag_ack,
    output logic sec_tick,
    output logic upd_warn,
    output logic per_flag
);
    typedef struct packed {
        logic tick;
        logic warn;
        logic flag;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tick = wrap_evt;
        if (warn_evt) begin
            st_d.warn = 1'b1;
        end else if (upd_done || hold) begin
            st_d.warn = 1'b0;
        end
        if (per_evt) begin
            st_d.flag = 1'b1;
        end else if (flag_ack) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_tick = st_q.tick;
    assign upd_warn = st_q.warn;
    assign per_flag = st_q.flag;

endmodule

// File: rtl/rtc_prescale_rate.sv
module rtc_prescale_rate #(
    parameter int         DIV_W     = 15,
    parameter int         WARN_LEAD = 8,
    parameter logic [6:0] RST_CFG   = 7'h26
) (
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [6:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       upd_done,
    input  logic       flag_ack,
    output logic       sec_tick,
    output logic       upd_warn,
    output logic       per_flag
);
    import rtcp_pkg::*;

    rtcp_cfg_t        cfg_d, cfg_q;
    logic             run, hold;
    logic [DIV_W-1:0] cnt;
    logic             wrap_evt, warn_evt, per_evt;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr) begin
            cfg_d = rtcp_cfg_t'(cfg_wdata);
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= rtcp_cfg_t'(RST_CFG);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run  = (cfg_q.dsel == DSEL_RUN);
    assign hold = (cfg_q.dsel == DSEL_HOLD);

    rtcp_div_chain #(.DIV_W(DIV_W), .WARN_LEAD(WARN_LEAD)) u_chain (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .run     (run),
        .hold    (hold),
        .cnt     (cnt),
        .wrap_evt(wrap_evt),
        .warn_evt(warn_evt)
    );

    rtcp_rate_tap #(.DIV_W(DIV_W)) u_rate (
        .cnt      (cnt),
        .run      (run),
        .rate_code(cfg_q.rsel),
        .per_evt  (per_evt)
    );

    rtcp_status u_stat (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .wrap_evt(wrap_evt),
        .warn_evt(warn_evt),
        .per_evt (per_evt),
        .upd_done(upd_done),
        .hold    (hold),
        .flag_ack(flag_ack),
        .sec_tick(sec_tick),
        .upd_warn(upd_warn),
        .per_flag(per_flag)
    );

    assign cfg_rdata = {upd_warn, cfg_q};

endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker (
    input logic       clk_osc,
    input logic       rst_n,
    input logic [7:0] cfg_rdata,
    input logic       upd_done,
    input logic       flag_ack,
    input logic       sec_tick,
    input logic       upd_warn,
    input logic       per_flag
);
    // R3: the tick lasts a single cycle
    assert_tick_single_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    // R4, R5: no tick follows a cycle spent outside run mode
    assert_no_tick_stopped_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (cfg_rdata[6:4] != 3'b010) |=> !sec_tick);

    // R8: rate code zero never raises the flag
    assert_rate_off_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!per_flag && cfg_rdata[3:0] == 4'd0) |=> !per_flag);

    // R9: the flag holds until acknowledged
    assert_flag_sticky_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (per_flag && !flag_ack) |=> per_flag);

    // R10: the warning holds until done or divider hold
    assert_warn_sticky_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (upd_warn && !upd_done && cfg_rdata[6:4] != 3'b111) |=> upd_warn);

endmodule

bind rtc_prescale_rate rtcp_checker u_rtcp_chk (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .cfg_rdata(cfg_rdata),
    .upd_done (upd_done),
    .flag_ack (flag_ack),
    .sec_tick (sec_tick),
    .upd_warn (upd_warn),
    .per_flag (per_flag)
);

// File: tb/rtc_prescale_rate_test.sv
module rtc_prescale_rate_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 199000;

    logic       clk_osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       upd_done = 1'b0;
    logic       flag_ack = 1'b0;
    logic [7:0] cfg_rdata;
    logic       sec_tick, upd_warn, per_flag;

    int  cyc = 0;
    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    rtc_prescale_rate uut (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .upd_done (upd_done),
        .flag_ack (flag_ack),
        .sec_tick (sec_tick),
        .upd_warn (upd_warn),
        .per_flag (per_flag)
    );

    always #(CLK_PERIOD/2) clk_osc = ~clk_osc;
    always @(posedge clk_osc) cyc <= cyc + 1;

    always @(negedge clk_osc) begin
        if (cyc > WD_LIMIT && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rate_period(input int code);
        int e;
        e = (code == 1) ? 8 : (code == 2) ? 9 : code;
        return (code == 0) ? 0 : (1 << (e - 1));
    endfunction

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [6:0] v, output int wedge);
        cfg_wr    = 1'b1;
        cfg_wdata = v;
        @(negedge clk_osc);
        wedge  = cyc;
        cfg_wr = 1'b0;
    endtask

    task automatic wait_tick(input int limit, output int at, output int warn_at);
        at = -1;
        warn_at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk_osc);
            if (upd_warn && warn_at < 0) warn_at = cyc;
            if (sec_tick) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic wait_flag(input int limit, output int at);
        at = -1;
        for (int k = 0; k < limit; k++) begin
            @(negedge clk_osc);
            if (per_flag) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic pulse_done();
        upd_done = 1'b1;
        @(negedge clk_osc);
        upd_done = 1'b0;
    endtask

    initial begin
        int w, w1, w2, t, t2, t3, wa, c1, c2, s_len, hits;
        int codes[15];
        void'($urandom(32'd7321));

        repeat (4) @(negedge clk_osc);
        rst_n = 1'b1;
        @(negedge clk_osc);
        // R1: reset state
        chk(cfg_rdata == 8'h26, "R1 cfg", int'(cfg_rdata), 'h26);
        chk({sec_tick, upd_warn, per_flag} == 3'b000, "R1 outputs",
            int'({sec_tick, upd_warn, per_flag}), 0);

        // R2: write and read back (hold mode, rate 3)
        wr(7'h73, w);
        chk(cfg_rdata == 8'h73, "R2 readback", int'(cfg_rdata), 'h73);
        flag_ack = 1'b1;
        @(negedge clk_osc);
        flag_ack = 1'b0;
        hits = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk_osc);
            if (sec_tick || per_flag) hits++;
        end
        chk(hits == 0, "R4/R11 hold quiet", hits, 0);

        // R4: half-second alignment after hold release; R10 warning lead
        wr(7'h26, w);
        wait_tick(20000, t, wa);
        chk(t == w + 16384, "R4 first tick", t - w, 16384);
        chk(wa == t - 8, "R10 warn lead", t - wa, 8);
        chk(cfg_rdata[7] == 1'b1, "R2 warn bit", int'(cfg_rdata[7]), 1);
        @(negedge clk_osc);
        chk(sec_tick == 1'b0, "R3 single pulse", int'(sec_tick), 0);
        repeat (20) @(negedge clk_osc);
        chk(upd_warn == 1'b1, "R10 warn held", int'(upd_warn), 1);
        pulse_done();
        chk(upd_warn == 1'b0, "R10 warn cleared", int'(upd_warn), 0);

        // R5 / R11: freeze for a random stretch
        repeat (1000) @(negedge clk_osc);
        flag_ack = 1'b1;
        wr(7'h06, w1);
        s_len = 200 + int'($urandom % 400);
        hits = 0;
        for (int k = 0; k < s_len; k++) begin
            @(negedge clk_osc);
            if (per_flag || sec_tick) hits++;
        end
        chk(hits == 0, "R11 frozen quiet", hits, 0);
        wr(7'h26, w2);
        wait_tick(40000, t2, wa);
        chk(t2 == t + 32768 + (w2 - w1), "R5 frozen delay", t2 - t, 32768 + (w2 - w1));
        pulse_done();

        // R3: steady one-second interval
        wait_tick(40000, t3, wa);
        chk(t3 == t2 + 32768, "R3 interval", t3 - t2, 32768);

        // R10: hold mode clears the warning
        chk(upd_warn == 1'b1, "R10 warn before hold", int'(upd_warn), 1);
        wr(7'h76, w);
        @(negedge clk_osc);
        chk(upd_warn == 1'b0, "R10 hold clears warn", int'(upd_warn), 0);

        // R6 / R7: every rate code, shuffled; ack held so set must win (R9)
        for (int i = 0; i < 15; i++) codes[i] = i + 1;
        for (int i = 14; i > 0; i--) begin
            int j, tmp;
            j = int'($urandom % (i + 1));
            tmp = codes[i];
            codes[i] = codes[j];
            codes[j] = tmp;
        end
        for (int i = 0; i < 15; i++) begin
            wr({3'b010, 4'(codes[i])}, w);
            repeat (2) @(negedge clk_osc);
            wait_flag(40000, c1);
            wait_flag(40000, c2);
            if (codes[i] <= 2)
                chk(c2 - c1 == rate_period(codes[i]), "R7 alias rate", c2 - c1, rate_period(codes[i]));
            else
                chk(c2 - c1 == rate_period(codes[i]), "R6 rate period", c2 - c1, rate_period(codes[i]));
        end

        // R8: rate code 0
        wr(7'h20, w);
        repeat (2) @(negedge clk_osc);
        hits = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk_osc);
            if (per_flag) hits++;
        end
        chk(hits == 0, "R8 rate off", hits, 0);

        // R9: sticky flag and acknowledge
        flag_ack = 1'b0;
        wr(7'h2A, w);
        wait_flag(2000, c1);
        chk(c1 >= 0, "R9 flag set", c1, 0);
        repeat (600) @(negedge clk_osc);
        chk(per_flag == 1'b1, "R9 flag held", int'(per_flag), 1);
        flag_ack = 1'b1;
        @(negedge clk_osc);
        flag_ack = 1'b0;
        chk(per_flag == 1'b0, "R9 flag cleared", int'(per_flag), 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule